// File: doc/BRIEF.md
# Twelve-Location Dual-Side PWM Sequencer

This block produces the switch gate pattern for an open-winding motor that is fed from both ends by two three-level inverters, called side A and side B. Once per sampling period it takes a location number m (1 to 12) on a twelve-sided polygon of voltage vectors, plus two dwell counts, all in clock ticks. It then applies location m, then the next location counter-clockwise, and then a zero state that belongs to location m. Each applied state is a triple of leg levels (0, 1, 2) per side. These levels are decoded into upper and lower switch gates, and each gate also has an inverted partner output.

On every side, each applied state puts exactly one leg at each level. The common-mode voltage of the two ends therefore stays the same, and the windings see no common-mode variation. Dead-band insertion is left to downstream logic. Location, dwell counts and period length are captured only at the first tick of a period, so the controller that supplies them can update them at any time.

Top module: `dual_twelve_vec_pwm`

## Requirements
- R1: A period lasts `period_ticks` clock ticks. The first period starts on the first rising edge after reset is released. `sector`, `t1_ticks`, `t2_ticks` and `period_ticks` are captured only on the edge that starts a period, so changes during a period have no effect on the outputs until the next period.
- R2: At tick k of a period (k = 0 at the start), location m is applied while k < T1. The next location (m+1, with 12 followed by 1) is applied while T1 <= k < T1+T2. The zero state of m is applied for the remaining ticks.
- R3: T1 is limited to the period length. T2 is then cut so that T1+T2 does not exceed the period length, which leaves a zero interval of length 0. A period length of 0 behaves as a one-tick period of zero state.
- R4: Active level triples (phase a, b, c), written as side A / side B: L1 201/012, L2 210/102, L3 120/012, L4 021/102, L5 120/201, L6 021/210, L7 012/201, L8 102/210, L9 012/120, L10 102/021, L11 201/120, L12 210/021.
- R5: The zero state of location L drives the same triple on both sides. When L mod 4 is 1 or 2, that triple is the side A triple of L. Otherwise it is the side B triple of L.
- R6: In every state applied for a valid location, each side has one leg at level 0, one at level 1 and one at level 2.
- R7: Gate decode per leg: level 2 gives upper=1 and lower=1, level 1 gives upper=0 and lower=1, level 0 gives upper=0 and lower=0. Bit 0 of each gate vector is phase a, bit 1 is phase b and bit 2 is phase c. An upper gate is never on while its lower gate is off.
- R8: Each `_n` output is the bitwise inverse of its partner gate vector at all times.
- R9: If the captured location is outside 1..12, `sector_err` is 1 for the whole period and every upper and lower gate is 0. `sector_err` is 0 during periods with a valid location.
- R10: While reset is asserted, and until the first edge after it is released, all upper and lower gates are 0 and `sector_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sector | input | 4 | Location m, valid 1..12 |
| t1_ticks | input | CNT_W | Dwell of location m in ticks |
| t2_ticks | input | CNT_W | Dwell of location m+1 in ticks |
| period_ticks | input | CNT_W | Sampling period length in ticks |
| a_up | output | 3 | Side A upper gates, bit 0 = phase a |
| a_up_n | output | 3 | Inverted partner of a_up |
| a_lo | output | 3 | Side A lower gates |
| a_lo_n | output | 3 | Inverted partner of a_lo |
| b_up | output | 3 | Side B upper gates |
| b_up_n | output | 3 | Inverted partner of b_up |
| b_lo | output | 3 | Side B lower gates |
| b_lo_n | output | 3 | Inverted partner of b_lo |
| sector_err | output | 1 | Captured location out of range |

## Verification
The case that is hardest to reach from the ports is an input change in the middle of a period. It must be ignored, and the new values must still be picked up at the boundary exactly one tick later. The bench drives altered location and dwell values just after the first tick of every period. It restores the intended next values only on the final tick, so any early capture shows up as a wrong gate pattern. The sweep covers all sixteen location codes, including the 12-to-1 wrap and the invalid codes. It also covers dwell pairs that overrun the period, fill it exactly, or are zero.

// File: rtl/dtv_pkg.sv
package dtv_pkg;
   localparam int NUM_LOC = 12;
   localparam int NUM_LEG = 3;
   localparam int SEC_W   = 4;

   typedef logic [1:0] lvl_t;
   typedef lvl_t [NUM_LEG-1:0] triple_t;   // index 0 = phase a

   typedef struct packed {
      triple_t side_a;
      triple_t side_b;
   } pair_t;

   function automatic triple_t mk(input int pa, input int pb, input int pc);
      triple_t t;
      t[0] = lvl_t'(pa);
      t[1] = lvl_t'(pb);
      t[2] = lvl_t'(pc);
      return t;
   endfunction

   // Level triples of the active vectors per polygon location
   function automatic pair_t active_pair(input logic [SEC_W-1:0] loc);
      pair_t p;
      case (loc)
         4'd1:    begin p.side_a = mk(2,0,1); p.side_b = mk(0,1,2); end
         4'd2:    begin p.side_a = mk(2,1,0); p.side_b = mk(1,0,2); end
         4'd3:    begin p.side_a = mk(1,2,0); p.side_b = mk(0,1,2); end
         4'd4:    begin p.side_a = mk(0,2,1); p.side_b = mk(1,0,2); end
         4'd5:    begin p.side_a = mk(1,2,0); p.side_b = mk(2,0,1); end
         4'd6:    begin p.side_a = mk(0,2,1); p.side_b = mk(2,1,0); end
         4'd7:    begin p.side_a = mk(0,1,2); p.side_b = mk(2,0,1); end
         4'd8:    begin p.side_a = mk(1,0,2); p.side_b = mk(2,1,0); end
         4'd9:    begin p.side_a = mk(0,1,2); p.side_b = mk(1,2,0); end
         4'd10:   begin p.side_a = mk(1,0,2); p.side_b = mk(0,2,1); end
         4'd11:   begin p.side_a = mk(2,0,1); p.side_b = mk(1,2,0); end
         4'd12:   begin p.side_a = mk(2,1,0); p.side_b = mk(0,2,1); end
         default: begin p.side_a = mk(0,0,0); p.side_b = mk(0,0,0); end
      endcase
      return p;
   endfunction

   // Zero state: side A triple when loc mod 4 is 1 or 2, else side B triple
   function automatic triple_t zero_triple(input logic [SEC_W-1:0] loc);
      pair_t p;
      p = active_pair(loc);
      return (loc[1] != loc[0]) ? p.side_a : p.side_b;
   endfunction
endpackage

// File: rtl/dtv_frame_timer.sv
module dtv_frame_timer
   import dtv_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SEC_W-1:0]    sector_in,
   input  logic [CNT_W-1:0]    t1_in,
   input  logic [CNT_W-1:0]    t2_in,
   input  logic [CNT_W-1:0]    ts_in,
   output logic                active,
   output logic [CNT_W-1:0]    cnt,
   output logic [SEC_W-1:0]    sector_q,
   output logic [CNT_W-1:0]    t1_q,
   output logic [CNT_W-1:0]    end2_q,
   output logic [CNT_W-1:0]    ts_q
);
   logic [CNT_W-1:0] t1_clip, rem, t2_clip;
   logic [CNT_W:0]   cnt_nx;
   logic             last, load;

   always_comb begin
      t1_clip = (t1_in > ts_in) ? ts_in : t1_in;
      rem     = ts_in - t1_clip;
      t2_clip = (t2_in > rem) ? rem : t2_in;
   end

   assign cnt_nx = {1'b0, cnt} + 1'b1;
   assign last   = (cnt_nx >= {1'b0, ts_q});
   assign load   = !active || last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cnt      <= '0;
         sector_q <= '0;
         t1_q     <= '0;
         end2_q   <= '0;
         ts_q     <= '0;
      end else if (load) begin
         active   <= 1'b1;
         cnt      <= '0;
         sector_q <= sector_in;
         t1_q     <= t1_clip;
         end2_q   <= t1_clip + t2_clip;
         ts_q     <= ts_in;
      end else begin
         cnt      <= cnt_nx[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/dtv_state_select.sv
module dtv_state_select
   import dtv_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                active,
   input  logic [CNT_W-1:0]    cnt,
   input  logic [SEC_W-1:0]    sector_q,
   input  logic [CNT_W-1:0]    t1_q,
   input  logic [CNT_W-1:0]    end2_q,
   output triple_t             lvl_a,
   output triple_t             lvl_b,
   output logic                err
);
   logic             valid;
   logic [SEC_W-1:0] next_loc;
   pair_t            pick;
   triple_t          zt;

   assign valid    = (sector_q >= SEC_W'(1)) && (sector_q <= SEC_W'(NUM_LOC));
   assign next_loc = (sector_q == SEC_W'(NUM_LOC)) ? SEC_W'(1) : sector_q + 1'b1;
   assign err      = active && !valid;

   always_comb begin
      zt = zero_triple(sector_q);
      if (!active || !valid) begin
         pick.side_a = '0;
         pick.side_b = '0;
      end else if (cnt < t1_q) begin
         pick = active_pair(sector_q);
      end else if (cnt < end2_q) begin
         pick = active_pair(next_loc);
      end else begin
         pick.side_a = zt;
         pick.side_b = zt;
      end
   end

   assign lvl_a = pick.side_a;
   assign lvl_b = pick.side_b;
endmodule

// File: rtl/dtv_leg_decode.sv
module dtv_leg_decode
   import dtv_pkg::*;
(
   input  triple_t              lvl,
   output logic [NUM_LEG-1:0]   up,
   output logic [NUM_LEG-1:0]   up_n,
   output logic [NUM_LEG-1:0]   lo,
   output logic [NUM_LEG-1:0]   lo_n
);
   for (genvar g = 0; g < NUM_LEG; g++) begin : g_leg
      assign up[g]   = (lvl[g] == 2'd2);
      assign up_n[g] = (lvl[g] != 2'd2);
      assign lo[g]   = (lvl[g] != 2'd0);
      assign lo_n[g] = (lvl[g] == 2'd0);
   end
endmodule

// File: rtl/dual_twelve_vec_pwm.sv
module dual_twelve_vec_pwm
   import dtv_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         sector,
   input  logic [CNT_W-1:0]   t1_ticks,
   input  logic [CNT_W-1:0]   t2_ticks,
   input  logic [CNT_W-1:0]   period_ticks,
   output logic [2:0]         a_up,
   output logic [2:0]         a_up_n,
   output logic [2:0]         a_lo,
   output logic [2:0]         a_lo_n,
   output logic [2:0]         b_up,
   output logic [2:0]         b_up_n,
   output logic [2:0]         b_lo,
   output logic [2:0]         b_lo_n,
   output logic               sector_err
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("dual_twelve_vec_pwm: CNT_W must lie in 2..32");
   end
   if (SEC_W != 4 || NUM_LEG != 3) begin : g_bad_pkg
      $error("dual_twelve_vec_pwm: package geometry mismatch");
   end

   logic               active;
   logic [CNT_W-1:0]   cnt;
   logic [SEC_W-1:0]   sector_q;
   logic [CNT_W-1:0]   t1_q, end2_q, ts_q;
   triple_t            lvl_a, lvl_b;

   dtv_frame_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .sector_in (sector),
      .t1_in     (t1_ticks),
      .t2_in     (t2_ticks),
      .ts_in     (period_ticks),
      .active    (active),
      .cnt       (cnt),
      .sector_q  (sector_q),
      .t1_q      (t1_q),
      .end2_q    (end2_q),
      .ts_q      (ts_q)
   );

   dtv_state_select #(.CNT_W(CNT_W)) u_select (
      .active   (active),
      .cnt      (cnt),
      .sector_q (sector_q),
      .t1_q     (t1_q),
      .end2_q   (end2_q),
      .lvl_a    (lvl_a),
      .lvl_b    (lvl_b),
      .err      (sector_err)
   );

   dtv_leg_decode u_dec_a (
      .lvl  (lvl_a),
      .up   (a_up),
      .up_n (a_up_n),
      .lo   (a_lo),
      .lo_n (a_lo_n)
   );

   dtv_leg_decode u_dec_b (
      .lvl  (lvl_b),
      .up   (b_up),
      .up_n (b_up_n),
      .lo   (b_lo),
      .lo_n (b_lo_n)
   );
endmodule

// File: rtl/dtv_checker.sv
module dtv_checker #(
   parameter int CNT_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               active,
   input logic [CNT_W-1:0]   cnt,
   input logic [CNT_W-1:0]   ts_q,
   input logic [2:0]         a_up,
   input logic [2:0]         a_up_n,
   input logic [2:0]         a_lo,
   input logic [2:0]         a_lo_n,
   input logic [2:0]         b_up,
   input logic [2:0]         b_up_n,
   input logic [2:0]         b_lo,
   input logic [2:0]         b_lo_n,
   input logic               sector_err
);
   // R1: tick count stays inside the captured period
   assert_count_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ts_q != '0) |-> (cnt < ts_q));

   // R6: one leg per level on each side for valid states
   assert_one_per_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !sector_err) |->
         ($countones(a_up) == 1 && $countones(a_lo) == 2 &&
          $countones(b_up) == 1 && $countones(b_lo) == 2));

   // R7: no upper gate on with its lower gate off
   assert_upper_needs_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((a_up & ~a_lo) == 3'b000) && ((b_up & ~b_lo) == 3'b000));

   // R8: partner outputs are inverses
   assert_partners_inverse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_up_n == ~a_up) && (a_lo_n == ~a_lo) && (b_up_n == ~b_up) && (b_lo_n == ~b_lo));

   // R9: error forces every gate to level-0
   assert_err_gates_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sector_err |-> ((a_up | a_lo | b_up | b_lo) == 3'b000));

   // R10: before the first period all gates are off and no error
   assert_idle_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (((a_up | a_lo | b_up | b_lo) == 3'b000) && !sector_err));
endmodule

bind dual_twelve_vec_pwm dtv_checker #(.CNT_W(CNT_W)) u_dtv_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .active     (active),
   .cnt        (cnt),
   .ts_q       (ts_q),
   .a_up       (a_up),
   .a_up_n     (a_up_n),
   .a_lo       (a_lo),
   .a_lo_n     (a_lo_n),
   .b_up       (b_up),
   .b_up_n     (b_up_n),
   .b_lo       (b_lo),
   .b_lo_n     (b_lo_n),
   .sector_err (sector_err)
);

// File: tb/dual_twelve_vec_pwm_bench.sv
module dual_twelve_vec_pwm_bench;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       sector = '0;
   logic [CNT_W-1:0] t1_ticks = '0, t2_ticks = '0, period_ticks = '0;
   logic [2:0]       a_up, a_up_n, a_lo, a_lo_n, b_up, b_up_n, b_lo, b_lo_n;
   logic             sector_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Spec tables (R4), triples written as decimal digits a,b,c
   int tab_a [0:12] = '{0, 201, 210, 120, 21, 120, 21, 12, 102, 12, 102, 201, 210};
   int tab_b [0:12] = '{0, 12, 102, 12, 102, 201, 210, 201, 210, 120, 21, 120, 21};

   int cfg_s [0:63];
   int cfg_1 [0:63];
   int cfg_2 [0:63];
   int cfg_t [0:63];
   int ncfg = 0;

   always #5 clk = ~clk;

   dual_twelve_vec_pwm #(.CNT_W(CNT_W)) u_dual_twelve_vec_pwm (
      .clk(clk), .rst_n(rst_n), .sector(sector),
      .t1_ticks(t1_ticks), .t2_ticks(t2_ticks), .period_ticks(period_ticks),
      .a_up(a_up), .a_up_n(a_up_n), .a_lo(a_lo), .a_lo_n(a_lo_n),
      .b_up(b_up), .b_up_n(b_up_n), .b_lo(b_lo), .b_lo_n(b_lo_n),
      .sector_err(sector_err)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   function automatic int dig(int x, int g);
      return (g == 0) ? (x / 100) % 10 : (g == 1) ? (x / 10) % 10 : x % 10;
   endfunction

   task automatic expect_vec(string tag, string what, logic [11:0] act, logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic add_cfg(int s, int a, int b, int t);
      cfg_s[ncfg] = s; cfg_1[ncfg] = a; cfg_2[ncfg] = b; cfg_t[ncfg] = t;
      ncfg++;
   endtask

   task automatic drive(int s, int a, int b, int t);
      sector       = 4'(s);
      t1_ticks     = CNT_W'(a);
      t2_ticks     = CNT_W'(b);
      period_ticks = CNT_W'(t);
   endtask

   task automatic check_tick(int s, int a, int b, int t, int k, bit junked, bit r4run);
      int t1c, t2c, ea, eb, nl, z, cu, cl;
      bit inval, clipped;
      string tag;
      logic [2:0] eau, eal, ebu, ebl;
      t1c     = (a > t) ? t : a;
      t2c     = (b > t - t1c) ? t - t1c : b;
      clipped = (a + b > t);
      inval   = (s < 1) || (s > 12);
      nl      = (s == 12) ? 1 : s + 1;
      if (inval) begin
         ea = 0; eb = 0; tag = "R9";
      end else if (k < t1c) begin
         ea = tab_a[s]; eb = tab_b[s]; tag = r4run ? "R4" : "R2";
      end else if (k < t1c + t2c) begin
         ea = tab_a[nl]; eb = tab_b[nl]; tag = "R2";
      end else begin
         z = ((s % 4 == 1) || (s % 4 == 2)) ? tab_a[s] : tab_b[s];
         ea = z; eb = z; tag = "R5";
      end
      if (!inval && clipped) tag = "R3";
      if (junked) tag = {tag, "/R1"};
      for (int g = 0; g < 3; g++) begin
         eau[g] = (dig(ea, g) == 2);
         eal[g] = (dig(ea, g) != 0);
         ebu[g] = (dig(eb, g) == 2);
         ebl[g] = (dig(eb, g) != 0);
      end
      expect_vec(tag, "gates{aup,alo,bup,blo}", {a_up, a_lo, b_up, b_lo}, {eau, eal, ebu, ebl});
      expect_vec(inval ? "R9" : "R9-valid", "sector_err", {11'd0, sector_err}, {11'd0, inval});
      expect_vec("R8", "partners", {a_up_n, a_lo_n, b_up_n, b_lo_n}, ~{a_up, a_lo, b_up, b_lo});
      expect_vec("R7", "upper-without-lower", {6'd0, a_up & ~a_lo, b_up & ~b_lo}, 12'd0);
      if (!inval) begin
         cu = $countones(a_up) * 16 + $countones(a_lo) * 4 + $countones(b_up) * 2 + $countones(b_lo);
         cl = 1 * 16 + 2 * 4 + 1 * 2 + 2;
         expect_vec("R6", "level counts", 12'(cu), 12'(cl));
      end
   endtask

   task automatic run_period(int i, bit r4run);
      int s, a, b, t, tt, j;
      bit junked;
      s = cfg_s[i]; a = cfg_1[i]; b = cfg_2[i]; t = cfg_t[i];
      j  = (i + 1 < ncfg) ? i + 1 : i;
      tt = (t == 0) ? 1 : t;
      junked = 0;
      for (int k = 0; k < tt; k++) begin
         @(negedge clk);
         check_tick(s, a, b, t, k, junked, r4run);
         if (k == tt - 1) begin
            drive(cfg_s[j], cfg_1[j], cfg_2[j], cfg_t[j]);
         end else if (k == 0) begin
            drive((s + 7) % 16, a + 1, b + 2, t + 3);
            junked = 1;
         end
      end
   endtask

   initial begin
      // R4 table sweep: whole period on location m
      for (int s = 1; s <= 12; s++) add_cfg(s, 5, 0, 5);
      // R2/R5/R9 sweep over all codes, including 12->1 wrap
      for (int s = 0; s < 16; s++) add_cfg(s, 2, 3, 8);
      // R3 clipping and boundary cases
      add_cfg(3, 9, 4, 6);
      add_cfg(7, 4, 5, 6);
      add_cfg(12, 0, 7, 4);
      add_cfg(5, 1, 1, 1);
      add_cfg(6, 0, 0, 3);
      add_cfg(9, 3, 3, 6);
      add_cfg(11, 0, 4, 7);
      add_cfg(2, 2, 1, 0);

      drive(cfg_s[0], cfg_1[0], cfg_2[0], cfg_t[0]);
      // R10: reset state
      for (int r = 0; r < 3; r++) begin
         @(negedge clk);
         expect_vec("R10", "reset gates", {a_up, a_lo, b_up, b_lo}, 12'd0);
         expect_vec("R10", "reset err", {11'd0, sector_err}, 12'd0);
      end
      rst_n = 1'b1;
      expect_vec("R10", "post-release gates", {a_up, a_lo, b_up, b_lo}, 12'd0);
      for (int i = 0; i < ncfg; i++) run_period(i, i < 12);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end
endmodule